// File: doc/BRIEF.md
# Synchronized Multi-Output Clock Divider

This block derives four clock outputs from one reference clock. Each output channel has its own integer divider, a bypass path, and a coarse phase offset. The divider ratio runs from 1 to 1024. In bypass the channel passes the reference clock straight through. The phase offset delays the channel's first rising edge by a whole number of reference cycles, so the channels can be placed relative to one another.

A parallel register port holds one configuration word per channel. A word that has been written is only staged. It reaches the running channel at the next restart event. There are three restart events:
- the release of the active-low sync input;
- the first cycle after reset is released while sync is high;
- the first cycle with no write after one or more writes, while sync is high.

Every restart reloads all four channels on the same edge, so they start phase-aligned. While sync is low every output is held low. While the active-low reset is asserted every output is held low, and every setting returns to its default.

Top module: `mcd_bank`

## Requirements
- R1: The 10-bit ratio field (word bits 9:0) selects the divide ratio. The value N from 2 to 1023 divides by N, and 0 divides by 1024, so each output period spans N reference cycles.
- R2: A divided output starts each period high. It stays high for (N+1)/2 cycles, rounded down, and low for the rest. Even ratios therefore give an exact half duty cycle.
- R3: A channel is in bypass when its bypass bit (word bit 20) is 1 or its ratio field is 1. In bypass the output is the reference clock gated by the channel's running state: high in the high half of each running cycle and low in the low half. The phase field has no effect in bypass.
- R4: The phase field (word bits 19:10) holds P. A divided channel stays low for P cycles after a restart event, then starts its first period. Its edges are therefore P cycles later than those of a channel with P equal to 0.
- R5: From the second rising clock edge after sync_n_i goes low, and for as long as it stays low, every output is low.
- R6: When sync_n_i goes high, all channels restart together on the second rising edge that sees it high. The first output change after the restart is a rising edge.
- R7: When reset is released with sync_n_i high, all channels restart on the second rising edge without any sync pulse.
- R8: A write stores the word for the channel chosen by wr_addr_i (0 to 3). The running channel is unaffected until a restart event. After a run of back-to-back writes with sync high, all channels restart on the first edge that sees wr_en_i low.
- R9: While rst_n_i is low every output is low. After release every channel has the default setting: ratio 2, phase 0, no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sync_n_i | input | 1 | Active-low hold; its release restarts all channels |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 2 | Channel index of the write |
| wr_data_i | input | 21 | Configuration word: bypass, phase, ratio |
| clk_o | output | 4 | Channel clock outputs |

## Verification
The hardest case to reach from the ports is a write burst during running operation. A correct design must keep every channel on its old pattern until the burst ends and then restart all of them on one edge. A faulty design that restarts on each write looks almost the same unless the phase is measured against the end of the burst. The stimulus therefore sets up ratios of 3, 4 and 5 on different channels and holds the write strobe for three cycles. It then checks the whole output vector on the three cycles that follow the expected restart edge. A restart at any other edge leaves at least one channel at a different point in its period. The bench also holds sync low while a bypass channel is running, to show that the gated reference clock is frozen too.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int unsigned DIV_W = 10;
    localparam int unsigned CFG_W = 2 * DIV_W + 1;

    typedef struct packed {
        logic             byp;
        logic [DIV_W-1:0] phase;
        logic [DIV_W-1:0] ratio;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_DEFAULT = '{byp: 1'b0, phase: '0, ratio: DIV_W'(2)};

    // field value 0 stands for the largest ratio
    function automatic logic [DIV_W:0] eff_ratio(input logic [DIV_W-1:0] f);
        return (f == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, f};
    endfunction

    function automatic logic is_pass(input chan_cfg_t c);
        return c.byp || (c.ratio == DIV_W'(1));
    endfunction
endpackage

// File: rtl/mcd_sync_ctrl.sv
module mcd_sync_ctrl (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sync_n_i,
    input  logic wr_en_i,
    output logic hold_o,
    output logic start_o
);
    typedef struct packed {
        logic sync;
        logic prev;
        logic pend;
    } sc_t;

    sc_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = sync_n_i;
        s_d.prev = s_q.sync;
        hold_o   = !s_q.sync;
        start_o  = s_q.sync && (!s_q.prev || (s_q.pend && !wr_en_i));
        if (wr_en_i) begin
            s_d.pend = 1'b1;
        end else if (start_o) begin
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mcd_cfg_regs.sv
module mcd_cfg_regs
    import mcd_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_n_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [CFG_W-1:0]             wr_data_i,
    output chan_cfg_t [NUM_CH-1:0]       cfg_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        chan_cfg_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
                slot_d = chan_cfg_t'(wr_data_i);
            end
        end

        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
                slot_q <= CFG_DEFAULT;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign cfg_o[g] = slot_q;
    end
endmodule

// File: rtl/mcd_chan.sv
module mcd_chan
    import mcd_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  logic      hold_i,
    input  logic      start_i,
    input  chan_cfg_t cfg_i,
    output logic      run_o,
    output logic      div_o,
    output logic      clk_o
);
    typedef struct packed {
        chan_cfg_t        act;
        logic [DIV_W-1:0] wait_cnt;
        logic [DIV_W:0]   cnt;
        logic             run;
        logic             out;
    } ch_t;

    ch_t            s_d, s_q;
    logic [DIV_W:0] last_q;
    logic [DIV_W:0] ratio_d;
    logic [DIV_W:0] high_d;

    always_comb begin
        s_d    = s_q;
        last_q = eff_ratio(s_q.act.ratio) - (DIV_W+1)'(1);
        if (hold_i) begin
            s_d.run = 1'b0;
        end else if (start_i) begin
            s_d.act      = cfg_i;
            s_d.wait_cnt = cfg_i.phase;
            s_d.cnt      = '0;
            s_d.run      = 1'b1;
        end else if (s_q.run) begin
            if (s_q.wait_cnt != '0) begin
                s_d.wait_cnt = s_q.wait_cnt - DIV_W'(1);
            end else if (s_q.cnt >= last_q) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + (DIV_W+1)'(1);
            end
        end
        ratio_d = eff_ratio(s_d.act.ratio);
        high_d  = (ratio_d + (DIV_W+1)'(1)) >> 1;
        s_d.out = s_d.run && !is_pass(s_d.act) && (s_d.wait_cnt == '0)
                  && (s_d.cnt < high_d);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            s_q     <= '0;
            s_q.act <= CFG_DEFAULT;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o = s_q.run;
    assign div_o = s_q.out;
    assign clk_o = is_pass(s_q.act) ? (clk_i & s_q.run) : s_q.out;
endmodule

// File: rtl/mcd_bank.sv
module mcd_bank
    import mcd_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sync_n_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    output logic [NUM_CH-1:0] clk_o
);
    chan_cfg_t [NUM_CH-1:0] cfg_w;
    logic                   hold_w;
    logic                   start_w;
    logic [NUM_CH-1:0]      run_vec;
    logic [NUM_CH-1:0]      div_vec;

    mcd_sync_ctrl u_sync (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .sync_n_i (sync_n_i),
        .wr_en_i  (wr_en_i),
        .hold_o   (hold_w),
        .start_o  (start_w)
    );

    mcd_cfg_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mcd_chan u_chan (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .hold_i  (hold_w),
            .start_i (start_w),
            .cfg_i   (cfg_w[g]),
            .run_o   (run_vec[g]),
            .div_o   (div_vec[g]),
            .clk_o   (clk_o[g])
        );
    end
endmodule

// File: rtl/mcd_bank_chk.sv
module mcd_bank_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              sync_n_i,
    input logic              wr_en_i,
    input logic              start_i,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] div_vec
);
    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R5
    hold_stops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !sync_n_i |-> ##2 (run_vec == '0));

    // R6
    joint_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(|run_vec) |-> (&run_vec));

    // R9
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (div_vec & ~run_vec) == '0);

    // R8
    write_defers_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (age_q == 2'd3 && wr_en_i && $past(sync_n_i, 2)) |-> !start_i);
endmodule

bind mcd_bank mcd_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .sync_n_i (sync_n_i),
    .wr_en_i  (wr_en_i),
    .start_i  (start_w),
    .run_vec  (run_vec),
    .div_vec  (div_vec)
);

// File: tb/mcd_bank_tb_top.sv
module mcd_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [20:0] wr_data = '0;
    logic [3:0]  clk_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mcd_bank dut_i (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .sync_n_i  (sync_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .clk_o     (clk_out)
    );

    // stimulus and expected high/low times
    localparam int TV_RATIO [8] = '{2, 3, 5, 8, 7, 1, 0, 4};
    localparam int TV_PHASE [8] = '{0, 1, 4, 3, 0, 2, 0, 2};
    localparam int TV_BYP   [8] = '{0, 0, 0, 0, 0, 0, 0, 1};
    localparam int TV_HI    [8] = '{1, 2, 3, 4, 4, 0, 512, 0};
    localparam int TV_LO    [8] = '{1, 1, 2, 4, 3, 0, 512, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_cfg(input int ch, input int byp, input int ph, input int ratio);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(ch);
        wr_data = {1'(byp), 10'(ph), 10'(ratio)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // returns at the negedge after the restart edge (t = 0)
    task automatic to_start();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: outputs low in reset
        repeat (3) @(negedge clk);
        chk(clk_out == 4'b0000, "R9 low during reset", int'(clk_out), 0);
        rst_n = 1'b1;
        // R7: automatic restart, default ratio 2
        to_start();
        chk(clk_out == 4'b1111, "R7 auto start t0", int'(clk_out), 15);
        @(negedge clk);
        chk(clk_out == 4'b0000, "R7 R9 default ratio t1", int'(clk_out), 0);
        @(negedge clk);
        chk(clk_out == 4'b1111, "R7 R9 default ratio t2", int'(clk_out), 15);

        // table walk: R1 R2 R3 R4
        for (int i = 0; i < 8; i++) begin
            int ch;
            int bad_t;
            int bad_v;
            int p;
            int n;
            ch = i % 4;
            @(negedge clk);
            sync_n = 1'b0;
            repeat (3) @(negedge clk);
            put_cfg(ch, TV_BYP[i], TV_PHASE[i], TV_RATIO[i]);
            sync_n = 1'b1;
            bad_t = -1;
            bad_v = 0;
            if (TV_HI[i] == 0) begin
                @(posedge clk);
                @(posedge clk);
                for (int t = 0; t < 6; t++) begin
                    #2;
                    if (clk_out[ch] !== 1'b1 && bad_t < 0) begin bad_t = 2 * t; bad_v = int'(clk_out[ch]); end
                    @(negedge clk);
                    #1;
                    if (clk_out[ch] !== 1'b0 && bad_t < 0) begin bad_t = 2 * t + 1; bad_v = int'(clk_out[ch]); end
                    @(posedge clk);
                end
                chk(bad_t < 0, $sformatf("R3 bypass entry %0d halfcycle %0d", i, bad_t), bad_v, (bad_t % 2 == 0) ? 1 : 0);
            end else begin
                p = TV_PHASE[i];
                n = TV_HI[i] + TV_LO[i];
                to_start();
                for (int t = 0; t < p + 2 * n; t++) begin
                    bit e;
                    e = (t >= p) && (((t - p) % n) < TV_HI[i]);
                    if (clk_out[ch] !== e && bad_t < 0) begin bad_t = t; bad_v = int'(clk_out[ch]); end
                    @(negedge clk);
                end
                chk(bad_t < 0, $sformatf("R1 R2 R4 entry %0d cycle %0d", i, bad_t), bad_v,
                    (bad_t >= p && ((bad_t - p) % n) < TV_HI[i]) ? 1 : 0);
            end
        end

        // R5: hold with a bypass channel (ch3) running
        @(negedge clk);
        sync_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        begin
            int seen;
            seen = 0;
            for (int t = 0; t < 5; t++) begin
                #2;
                seen = seen | int'(clk_out);
                @(negedge clk);
                seen = seen | int'(clk_out);
                @(posedge clk);
            end
            chk(seen == 0, "R5 all outputs held low", seen, 0);
        end

        // R6: joint restart on release
        put_cfg(0, 0, 0, 4);
        put_cfg(1, 0, 0, 6);
        put_cfg(2, 0, 0, 3);
        put_cfg(3, 0, 0, 5);
        chk(clk_out == 4'b0000, "R5 still low after writes", int'(clk_out), 0);
        sync_n = 1'b1;
        to_start();
        chk(clk_out == 4'b1111, "R6 aligned rise t0", int'(clk_out), 15);
        @(negedge clk);
        chk(clk_out == 4'b1111, "R6 t1", int'(clk_out), 15);
        @(negedge clk);
        chk(clk_out == 4'b1010, "R6 t2", int'(clk_out), 10);

        // R8: burst of three writes, restart on first idle edge
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'd1;
        wr_data = {1'b0, 10'd1, 10'd2};
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(clk_out == 4'b1101, "R8 restart after burst t0", int'(clk_out), 13);
        @(negedge clk);
        chk(clk_out == 4'b1111, "R8 t1", int'(clk_out), 15);
        @(negedge clk);
        chk(clk_out == 4'b1000, "R8 t2", int'(clk_out), 8);

        // R9: reset restores defaults
        put_cfg(0, 0, 0, 5);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(clk_out == 4'b0000, "R9 low in second reset", int'(clk_out), 0);
        rst_n = 1'b1;
        to_start();
        chk(clk_out == 4'b1111, "R9 defaults t0", int'(clk_out), 15);
        @(negedge clk);
        chk(clk_out == 4'b0000, "R9 defaults t1", int'(clk_out), 0);
        @(negedge clk);
        chk(clk_out == 4'b1111, "R9 defaults t2", int'(clk_out), 15);

        finish_run();
    end
endmodule